// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Byte Store Write Controller

This block fronts a byte-addressable nonvolatile data store. Software first loads bytes into a one-row buffer of column latches. Each latch has a ninth "written" bit. Software then commits that buffer with a two-byte key written to a key register. During a timed programming phase, only the marked bytes are copied into the row that was captured by the first buffered write. Every other byte of that row keeps its old value.

A busy flag covers the whole programming phase. While it is set, buffered writes are refused, and reads return a blank byte together with an error strobe. Reads are stretched by one wait state, so data arrives two cycles after the request. The store sits behind an enable bit in a mode register. When the bit is clear, accesses are redirected to ordinary RAM through a select output.

The 11-bit address splits into a 4-bit row field (bits 10:7) and a 7-bit column field (bits 6:0). With the default parameters the store holds 8 rows of 128 bytes, which is 1024 bytes. Rows 8 to 15 have no storage: writes to them are dropped and reads from them return 0xFF.

Top module: `nvm_page_writer`

## Requirements
- R1: After reset, busy_o and rd_valid_o are 0, all column-latch marks are clear, no row is captured, and every stored byte reads as 0xFF.
- R2: The enable bit is bit 0 of the mode register, written with ctrl_we=1 and ctrl_sel=0. While it is 0, a bus access drives ram_sel_o high, a bus write changes no latch, and a bus read produces no rd_valid_o.
- R3: An enabled bus write that is not refused stores bus_wdata in the latch at column bus_addr[6:0] and marks it. If no row is captured yet, the row field bus_addr[10:7] is captured.
- R4: While a row is captured, a bus write whose row field differs from it is discarded.
- R5: Programming starts only when a key-register write (ctrl_we=1, ctrl_sel=1) of 0xA2 directly follows a key-register write of 0x52. Any other key write in between clears the armed state.
- R6: When programming ends, each marked latch is written into its column of the captured row. Unmarked columns of that row keep their old contents.
- R7: busy_o rises in the cycle after the 0xA2 key write is accepted and stays high for exactly PROG_CYCLES cycles.
- R8: When programming ends, all marks are cleared and the captured row is released. A later session may use any row and leaves every column it did not write untouched.
- R9: A read requested while busy_o is high completes with rd_data_o = 0xFF and rd_err_o = 1.
- R10: A read requested at clock edge k gives rd_valid_o = 1 with the stored byte after edge k+1, which is one wait state more than a single-cycle RAM.
- R11: Bus writes made while busy_o is high change no latch, so they cannot alter the byte that is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe to the store's address range |
| bus_we | input | 1 | 1 = write, 0 = read for the current access |
| bus_addr | input | ADDR_W | Byte address: row field on top, column field below |
| bus_wdata | input | 8 | Write byte |
| ctrl_we | input | 1 | Control-side register write strobe |
| ctrl_sel | input | 1 | 0 = mode register, 1 = key register |
| ctrl_wdata | input | 8 | Control register write byte |
| ram_sel_o | output | 1 | Access belongs to ordinary RAM (store disabled) |
| busy_o | output | 1 | Programming in progress |
| rd_valid_o | output | 1 | Read result valid |
| rd_err_o | output | 1 | Read was refused because programming was in progress |
| rd_data_o | output | 8 | Read byte |

## Verification
The assertions assume that bus_sel, bus_we and the control strobes are never asserted together with reset. They also assume that the 0xA2 key write which starts programming is the only event that raises busy, so a busy rise always follows an accepted key write by one cycle. The stimulus drives every strobe for exactly one cycle, starting at a falling edge, and waits for busy to drop before it starts a new session. The only exceptions are the deliberate refused reads and writes made during programming. All addresses stay in rows that have storage, so the latch's row-hold property is exercised only through legitimate captures.

// File: rtl/nvm_page_pkg.sv
package nvm_page_pkg;

    localparam logic [7:0] KEY_ARM = 8'h52;
    localparam logic [7:0] KEY_GO  = 8'hA2;
    localparam logic [7:0] BLANK   = 8'hFF;

    typedef enum logic {
        CSEL_MODE = 1'b0,
        CSEL_KEY  = 1'b1
    } csel_e;

endpackage

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
    import nvm_page_pkg::*;
#(
    parameter int PROG_CYCLES = 16,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we_i,
    input  logic [7:0] key_data_i,
    output logic       busy_o,
    output logic       commit_o
);

    typedef struct packed {
        logic             armed;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic commit_d;

    always_comb begin
        s_d      = s_q;
        commit_d = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                commit_d = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (key_we_i) begin
            if (s_q.busy) begin
                s_d.armed = 1'b0;
            end else if (s_q.armed && key_data_i == KEY_GO) begin
                s_d.armed = 1'b0;
                s_d.busy  = 1'b1;
                s_d.cnt   = CNT_W'(PROG_CYCLES - 1);
            end else begin
                s_d.armed = (key_data_i == KEY_ARM);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = s_q.busy;
    assign commit_o = commit_d;

    // R7: busy must not drop before the counter runs out
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> s_q.busy);

    // R5: a non-key value written while armed disarms the detector
    p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we_i && key_data_i != KEY_ARM && key_data_i != KEY_GO) |=> !s_q.armed);

endmodule

// File: rtl/nvm_col_latch.sv
module nvm_col_latch #(
    parameter int ROW_W = 4,
    parameter int COL_W = 7,
    localparam int ROW_BYTES = 1 << COL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [ROW_W-1:0]              wr_row_i,
    input  logic [COL_W-1:0]              wr_col_i,
    input  logic [7:0]                    wr_data_i,
    input  logic                          commit_i,
    output logic [ROW_BYTES-1:0][7:0]     lat_data_o,
    output logic [ROW_BYTES-1:0]          lat_flag_o,
    output logic [ROW_W-1:0]              row_o
);

    typedef struct packed {
        logic [ROW_BYTES-1:0][7:0] data;
        logic [ROW_BYTES-1:0]      flag;
        logic [ROW_W-1:0]          row;
        logic                      locked;
    } lat_t;

    lat_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (commit_i) begin
            l_d.flag   = '0;
            l_d.locked = 1'b0;
        end else if (wr_en_i && (!l_q.locked || wr_row_i == l_q.row)) begin
            l_d.data[wr_col_i] = wr_data_i;
            l_d.flag[wr_col_i] = 1'b1;
            if (!l_q.locked) begin
                l_d.locked = 1'b1;
                l_d.row    = wr_row_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign lat_data_o = l_q.data;
    assign lat_flag_o = l_q.flag;
    assign row_o      = l_q.row;

    // R4: a captured row stays put until the programming phase ends
    p_row_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.locked && !commit_i) |=> (l_q.locked && $stable(l_q.row)));

    // R8: end of programming leaves an empty, unlocked latch set
    p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (l_q.flag == '0 && !l_q.locked));

    // R3: a flag is only set when a latch write was offered
    p_flag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(l_q.flag) > $countones($past(l_q.flag))) |-> $past(wr_en_i));

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int ROWS = 8,
    parameter int COL_W = 7,
    localparam int ROW_BYTES = 1 << COL_W,
    localparam int ROW_IDX_W = $clog2(ROWS),
    localparam int IDX_W = ROW_IDX_W + COL_W,
    localparam int DEPTH = ROWS * ROW_BYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit_i,
    input  logic [ROW_IDX_W-1:0]      commit_row_i,
    input  logic [ROW_BYTES-1:0][7:0] lat_data_i,
    input  logic [ROW_BYTES-1:0]      lat_flag_i,
    input  logic [IDX_W-1:0]          rd_idx_i,
    output logic [7:0]                rd_byte_o
);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (commit_i) begin
            for (int c = 0; c < ROW_BYTES; c++) begin
                if (lat_flag_i[c]) begin
                    mem_d[{commit_row_i, COL_W'(c)}] = lat_data_i[c];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_byte_o = mem_q[rd_idx_i];

    // R6: column 0 of the committed row changes only when its latch was marked
    p_keep_unmarked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !lat_flag_i[0]) |=>
            (mem_q[{$past(commit_row_i), COL_W'(0)}] == $past(mem_q[{commit_row_i, COL_W'(0)}])));

endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
    import nvm_page_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int ROW_W = 4,
    parameter int ROWS = 8,
    parameter int PROG_CYCLES = 16,
    localparam int COL_W = ADDR_W - ROW_W,
    localparam int ROW_BYTES = 1 << COL_W,
    localparam int ROW_IDX_W = $clog2(ROWS),
    localparam int IDX_W = ROW_IDX_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              ctrl_we,
    input  logic              ctrl_sel,
    input  logic [7:0]        ctrl_wdata,
    output logic              ram_sel_o,
    output logic              busy_o,
    output logic              rd_valid_o,
    output logic              rd_err_o,
    output logic [7:0]        rd_data_o
);

    localparam logic [ROW_W:0] ROW_LIM = (ROW_W + 1)'(ROWS);

    typedef struct packed {
        logic             en;
        logic             rq_valid;
        logic             rq_err;
        logic             rq_blank;
        logic [IDX_W-1:0] rq_idx;
        logic             rv;
        logic             rerr;
        logic [7:0]       rdata;
    } top_t;

    top_t t_d, t_q;

    logic                      busy;
    logic                      commit;
    logic                      key_we;
    logic                      access;
    logic                      wr_en;
    logic                      row_ok;
    logic                      commit_ok;
    logic [ROW_W-1:0]          row_in;
    logic [COL_W-1:0]          col_in;
    logic [ROW_W-1:0]          lat_row;
    logic [ROW_BYTES-1:0][7:0] lat_data;
    logic [ROW_BYTES-1:0]      lat_flag;
    logic [7:0]                rd_byte;

    assign row_in    = bus_addr[ADDR_W-1 -: ROW_W];
    assign col_in    = bus_addr[COL_W-1:0];
    assign row_ok    = {1'b0, row_in} < ROW_LIM;
    assign key_we    = ctrl_we && (ctrl_sel == CSEL_KEY);
    assign access    = bus_sel && t_q.en;
    assign wr_en     = access && bus_we && !busy && row_ok;
    assign commit_ok = commit && ({1'b0, lat_row} < ROW_LIM);

    always_comb begin
        t_d = t_q;
        if (ctrl_we && ctrl_sel == CSEL_MODE) begin
            t_d.en = ctrl_wdata[0];
        end
        // stage A: capture the read request (wait state)
        t_d.rq_valid = access && !bus_we;
        if (access && !bus_we) begin
            t_d.rq_err   = busy;
            t_d.rq_blank = !row_ok;
            t_d.rq_idx   = {row_in[ROW_IDX_W-1:0], col_in};
        end
        // stage B: deliver the byte
        t_d.rv   = t_q.rq_valid;
        t_d.rerr = t_q.rq_valid && t_q.rq_err;
        if (t_q.rq_valid) begin
            t_d.rdata = (t_q.rq_err || t_q.rq_blank) ? BLANK : rd_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    nvm_seq_ctrl #(
        .PROG_CYCLES (PROG_CYCLES)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_we_i   (key_we),
        .key_data_i (ctrl_wdata),
        .busy_o     (busy),
        .commit_o   (commit)
    );

    nvm_col_latch #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) latch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_row_i   (row_in),
        .wr_col_i   (col_in),
        .wr_data_i  (bus_wdata),
        .commit_i   (commit),
        .lat_data_o (lat_data),
        .lat_flag_o (lat_flag),
        .row_o      (lat_row)
    );

    nvm_store #(
        .ROWS  (ROWS),
        .COL_W (COL_W)
    ) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit_ok),
        .commit_row_i (lat_row[ROW_IDX_W-1:0]),
        .lat_data_i   (lat_data),
        .lat_flag_i   (lat_flag),
        .rd_idx_i     (t_q.rq_idx),
        .rd_byte_o    (rd_byte)
    );

    assign ram_sel_o  = bus_sel && !t_q.en;
    assign busy_o     = busy;
    assign rd_valid_o = t_q.rv;
    assign rd_err_o   = t_q.rerr;
    assign rd_data_o  = t_q.rdata;

    // R5: programming only begins right after a key write of the commit byte
    p_start_after_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(key_we && ctrl_wdata == KEY_GO));

    // R9: a refused read always carries the blank byte
    p_err_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o |-> (rd_valid_o && rd_data_o == BLANK));

    // R2: no read result without an enabled read request two edges back
    p_valid_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid_o) |-> $past(t_q.rq_valid));

endmodule

// File: tb/nvm_page_writer_tb_top.sv
module nvm_page_writer_tb_top;

    localparam int PROG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic        ctrl_sel = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic        ram_sel_o, busy_o, rd_valid_o, rd_err_o;
    logic [7:0]  rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] model [1024];
    logic [7:0] pend  [128];
    bit         pflag [128];
    bit         m_en = 1'b0;
    bit         m_locked = 1'b0;
    int         m_row = 0;

    // {addr[10:0], data[7:0]}
    localparam logic [18:0] VEC [8] = '{
        {11'h180, 8'hA1}, {11'h181, 8'hB2}, {11'h1FF, 8'hC3}, {11'h280, 8'hD4},
        {11'h1C0, 8'hE5}, {11'h181, 8'hF6}, {11'h2A0, 8'h17}, {11'h190, 8'h28}
    };

    always #5 clk = ~clk;

    nvm_page_writer #(.PROG_CYCLES(PROG)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ctrl_we    (ctrl_we),
        .ctrl_sel   (ctrl_sel),
        .ctrl_wdata (ctrl_wdata),
        .ram_sel_o  (ram_sel_o),
        .busy_o     (busy_o),
        .rd_valid_o (rd_valid_o),
        .rd_err_o   (rd_err_o),
        .rd_data_o  (rd_data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_en(input bit b);
        ctrl_we = 1'b1; ctrl_sel = 1'b0; ctrl_wdata = {7'd0, b};
        @(negedge clk);
        ctrl_we = 1'b0;
        m_en = b;
    endtask

    task automatic key(input logic [7:0] d);
        ctrl_we = 1'b1; ctrl_sel = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    // model_on = 0 for writes the bench expects to be refused for busy
    task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit model_on);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (model_on && m_en && a[10:7] < 8) begin
            if (!m_locked) begin
                m_locked = 1'b1;
                m_row = int'(a[10:7]);
            end
            if (int'(a[10:7]) == m_row) begin
                pend[a[6:0]]  = d;
                pflag[a[6:0]] = 1'b1;
            end
        end
    endtask

    task automatic rd(input logic [10:0] a, input string req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
        chk(rd_valid_o === 1'b1 && rd_err_o === 1'b0, req, {rd_valid_o, rd_err_o}, 2'b10);
        chk(rd_data_o === model[a], req, rd_data_o, model[a]);
    endtask

    task automatic model_commit();
        for (int c = 0; c < 128; c++) begin
            if (pflag[c]) model[m_row * 128 + c] = pend[c];
            pflag[c] = 1'b0;
        end
        m_locked = 1'b0;
    endtask

    task automatic program_wait();
        while (busy_o) @(negedge clk);
        model_commit();
    endtask

    task automatic program_count(input string req);
        int n = 0;
        key(8'h52);
        key(8'hA2);
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(n == PROG, req, n, PROG);
        model_commit();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
        for (int c = 0; c < 128; c++) begin pend[c] = 8'h00; pflag[c] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(busy_o === 1'b0 && rd_valid_o === 1'b0, "R1", {busy_o, rd_valid_o}, 0);

        // R2: disabled store routes to RAM and ignores accesses
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 11'h005; bus_wdata = 8'h11;
        #1;
        chk(ram_sel_o === 1'b1, "R2", ram_sel_o, 1);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        bus_sel = 1'b1; bus_addr = 11'h005;
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
        chk(rd_valid_o === 1'b0, "R2", rd_valid_o, 0);
        set_en(1'b1);
        rd(11'h000, "R1");
        wr(11'h001, 8'h22, 1'b1);
        program_count("R7");
        rd(11'h005, "R2");
        rd(11'h001, "R3");

        // vector table: row capture, discarded rows, overwrite, then program
        for (int v = 0; v < 8; v++) begin
            wr(VEC[v][18:8], VEC[v][7:0], 1'b1);
        end
        program_count("R7");
        for (int v = 0; v < 8; v++) begin
            rd(VEC[v][18:8], (VEC[v][18:15] == 4'd3) ? "R6" : "R4");
        end
        rd(11'h1A0, "R6");

        // R8: new session on row 6; stale marks must not leak in
        wr(11'h310, 8'h3C, 1'b1);
        program_count("R8");
        rd(11'h300, "R8");
        rd(11'h37F, "R8");
        rd(11'h310, "R8");

        // R5: broken key sequences do not start programming
        wr(11'h200, 8'h66, 1'b1);
        key(8'hA2);
        chk(busy_o === 1'b0, "R5", busy_o, 0);
        key(8'h52); key(8'h00); key(8'hA2);
        chk(busy_o === 1'b0, "R5", busy_o, 0);
        rd(11'h200, "R5");
        key(8'h52); key(8'h52); key(8'hA2);
        chk(busy_o === 1'b1, "R5", busy_o, 1);
        program_wait();
        rd(11'h200, "R5");

        // R9 and R11: reads and writes during programming
        wr(11'h1C0, 8'h55, 1'b1);
        key(8'h52); key(8'hA2);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 11'h1C0;
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
        chk(rd_valid_o === 1'b1 && rd_err_o === 1'b1, "R9", {rd_valid_o, rd_err_o}, 2'b11);
        chk(rd_data_o === 8'hFF, "R9", rd_data_o, 8'hFF);
        wr(11'h1C0, 8'h99, 1'b0);
        wr(11'h1C1, 8'h77, 1'b0);
        program_wait();
        rd(11'h1C0, "R11");
        rd(11'h1C1, "R11");

        // R10: result appears exactly after the second edge
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 11'h190;
        @(negedge clk);
        bus_sel = 1'b0;
        chk(rd_valid_o === 1'b0, "R10", rd_valid_o, 0);
        @(negedge clk);
        chk(rd_valid_o === 1'b1 && rd_data_o === 8'h28, "R10", rd_data_o, 8'h28);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule